// File: doc/BRIEF.md
# Multi-Rate Serial Rate Search Controller

This block is the digital control loop of a multi-rate serial video reclocker. In automatic mode it steps the clock-recovery loop through six candidate bit rates, giving each one a fixed dwell time. It stops on the first rate whose measured frequency matches the expected value. In manual mode it holds the one rate the user commands and never searches.

Frequency is judged by counting recovered-clock events over a fixed window of reference clocks. The recovered clock arrives as a toggle signal, one toggle per event. At the nominal rate, the expected count over 2048 reference cycles equals the rate in Mb/s. Lock is declared when a full window lands within ±2% of the expected count for the rate under trial. Lock is dropped as soon as a window falls outside that band, and acquisition then restarts.

Outputs are a 3-bit rate code with an output-enable, a lock flag and a standard/high-definition indicator. All control inputs and the recovered toggle are treated as asynchronous.

Top module: `rate_search_ctrl`

## Requirements
- R1: Rate codes map as 000=143, 001=177, 010=270, 011=360, 100=540, 101=1485 Mb/s. Lock is reached only when a full window's toggle count lies within ±2% of rate×2^WIN_LOG2/2048.
- R2: After reset in automatic mode, the trial starts at code 000. Each code is tried for DWELL_CYCLES reference cycles, and the trial then advances in ascending code order. After 101 it wraps back to 000.
- R3: While skip177 is high, automatic mode never tries code 001: the trial moves from 000 straight to 010. skip177 has no effect in manual mode.
- R4: In automatic mode, rateCodeOe is 1 and rateCode shows the rate currently locked, or else the last rate locked. rateCode is 000 after reset before any lock.
- R5: In manual mode, rateCodeOe is 0 and no search takes place. Lock can occur only at the code given on manualRate.
- R6: A manual code of 110 or 111 is tried as 143 Mb/s and never produces lock.
- R7: sdHd is 0 while code 101 is being tried or is locked, and 1 for every other code. As a result it toggles during an unlocked automatic search.
- R8: lockDet is active high. A window outside tolerance clears it and restarts the dwell at the same rate. From there, scanning resumes in automatic mode.
- R9: Every input passes through two flip-flops. A change on autoMode shows on rateCodeOe after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| autoMode | input | 1 | 1 = automatic search, 0 = manual rate |
| skip177 | input | 1 | Removes code 001 from the automatic search |
| manualRate | input | 3 | Commanded rate code in manual mode |
| recToggle | input | 1 | Toggles once per recovered-clock event |
| rateCode | output | 3 | Locked / last-locked rate code |
| rateCodeOe | output | 1 | Output enable for rateCode (automatic mode) |
| lockDet | output | 1 | Lock detected |
| sdHd | output | 1 | 0 for the high-definition rate, 1 otherwise |

## Verification
If the trial pointer is corrupt, the error shows at the ports through the lock time and sdHd. The block locks a whole dwell early or late, locks on the wrong rateCode, or shows sdHd low outside the 101 trial, all within one dwell period. A wrong window count or tolerance compare shows up one window (2048 cycles) after the signal is applied or changed: lockDet stays low for an in-band signal, rises for an off-band one, or fails to drop. A broken mode or skip path shows up either as a lock where none should happen or as rateCodeOe taking the wrong value two cycles after the input changes.

// File: rtl/rate_search_pkg.sv
package rate_search_pkg;
  typedef logic [2:0] rate_t;

  localparam rate_t RATE_143 = 3'd0;
  localparam rate_t RATE_177 = 3'd1;
  localparam rate_t RATE_270 = 3'd2;
  localparam rate_t RATE_HD  = 3'd5;
  localparam int unsigned NUM_RATES = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear window, count and dwell
    logic dwellEn;   // dwell timer runs while searching
  } ctrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic winDone;
    logic inTol;
    logic dwellDone;
  } stat_t;

  function automatic int unsigned rateMbps(rate_t c);
    case (c)
      3'd0:    return 143;
      3'd1:    return 177;
      3'd2:    return 270;
      3'd3:    return 360;
      3'd4:    return 540;
      3'd5:    return 1485;
      default: return 143;
    endcase
  endfunction
endpackage

// File: rtl/rate_sync.sv
module rate_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/rate_meas_dp.sv
module rate_meas_dp
  import rate_search_pkg::*;
#(
  parameter int WIN_LOG2     = 11,
  parameter int DWELL_CYCLES = 2200
) (
  input  logic  clk,
  input  logic  rstN,
  input  ctrl_t ctrl,
  input  rate_t curRate,
  input  logic  recToggleS,
  output stat_t stat
);
  localparam int CW = WIN_LOG2 + 1;
  localparam int DW = $clog2(DWELL_CYCLES + 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_CYCLES - 1);

  logic            togPrev;
  logic            tick;
  logic [WIN_LOG2-1:0] winCnt;
  logic [CW-1:0]   edgeCnt;
  logic [CW-1:0]   countNow;
  logic [DW-1:0]   dwellCnt;
  logic [31:0]     expCnt;
  logic [31:0]     scaled;

  assign tick     = recToggleS ^ togPrev;
  assign countNow = edgeCnt + CW'(tick);
  assign expCnt   = (32'(rateMbps(curRate)) << WIN_LOG2) >> 11;
  assign scaled   = 32'(countNow) * 32'd50;

  assign stat.winDone   = &winCnt;
  assign stat.inTol     = (scaled >= expCnt * 32'd49) && (scaled <= expCnt * 32'd51);
  assign stat.dwellDone = (dwellCnt == DWELL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togPrev  <= 1'b0;
      winCnt   <= '0;
      edgeCnt  <= '0;
      dwellCnt <= '0;
    end else begin
      togPrev <= recToggleS;
      if (ctrl.restart) begin
        winCnt   <= '0;
        edgeCnt  <= '0;
        dwellCnt <= '0;
      end else begin
        winCnt  <= winCnt + 1'b1;
        edgeCnt <= stat.winDone ? '0 : countNow;
        if (ctrl.dwellEn && !stat.dwellDone) dwellCnt <= dwellCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rate_search_fsm.sv
module rate_search_fsm
  import rate_search_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  autoS,
  input  logic  skipS,
  input  rate_t manualS,
  input  stat_t stat,
  output ctrl_t ctrl,
  output rate_t curRate,
  output logic  locked,
  output rate_t lastLocked
);
  logic  autoPrev;
  logic  manualValid;
  rate_t manualMapped;
  rate_t nextRate;
  logic  lockAllowed;
  logic  goodWin;
  logic  badWin;
  rate_t curN;
  rate_t lastN;
  logic  lockedN;
  logic  restartN;

  assign manualValid  = manualS < rate_t'(NUM_RATES);
  assign manualMapped = manualValid ? manualS : RATE_143;

  always_comb begin
    nextRate = (curRate == RATE_HD) ? RATE_143 : curRate + 3'd1;
    if (nextRate == RATE_177 && skipS) nextRate = RATE_270;
  end

  assign lockAllowed = autoS ? !(skipS && curRate == RATE_177) : manualValid;
  assign goodWin     = stat.winDone && stat.inTol && lockAllowed;
  assign badWin      = stat.winDone && !stat.inTol;

  always_comb begin
    curN     = curRate;
    lastN    = lastLocked;
    lockedN  = locked;
    restartN = 1'b0;
    if (autoS != autoPrev) begin
      lockedN  = 1'b0;
      restartN = 1'b1;
    end else if (!autoS && manualMapped != curRate) begin
      curN     = manualMapped;
      lockedN  = 1'b0;
      restartN = 1'b1;
    end else if (autoS && skipS && curRate == RATE_177) begin
      curN     = nextRate;
      lockedN  = 1'b0;
      restartN = 1'b1;
    end else if (locked) begin
      if (badWin || !lockAllowed) begin
        lockedN  = 1'b0;
        restartN = 1'b1;
      end
    end else if (goodWin) begin
      lockedN = 1'b1;
      lastN   = curRate;
    end else if (autoS && stat.dwellDone) begin
      curN     = nextRate;
      restartN = 1'b1;
    end
  end

  assign ctrl.restart = restartN;
  assign ctrl.dwellEn = !locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoPrev   <= 1'b0;
      curRate    <= RATE_143;
      lastLocked <= RATE_143;
      locked     <= 1'b0;
    end else begin
      autoPrev   <= autoS;
      curRate    <= curN;
      lastLocked <= lastN;
      locked     <= lockedN;
    end
  end
endmodule

// File: rtl/rate_search_ctrl.sv
module rate_search_ctrl
  import rate_search_pkg::*;
#(
  parameter int WIN_LOG2     = 11,
  parameter int DWELL_CYCLES = 2200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoMode,
  input  logic       skip177,
  input  logic [2:0] manualRate,
  input  logic       recToggle,
  output logic [2:0] rateCode,
  output logic       rateCodeOe,
  output logic       lockDet,
  output logic       sdHd
);
  logic  autoS;
  logic  skipS;
  rate_t manualS;
  logic  recToggleS;
  ctrl_t ctrl;
  stat_t stat;
  rate_t curRate;
  rate_t lastLocked;
  logic  locked;

  rate_sync #(.W(6)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({autoMode, skip177, manualRate, recToggle}),
    .dout({autoS, skipS, manualS, recToggleS})
  );

  rate_meas_dp #(.WIN_LOG2(WIN_LOG2), .DWELL_CYCLES(DWELL_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .curRate   (curRate),
    .recToggleS(recToggleS),
    .stat      (stat)
  );

  rate_search_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .autoS     (autoS),
    .skipS     (skipS),
    .manualS   (manualS),
    .stat      (stat),
    .ctrl      (ctrl),
    .curRate   (curRate),
    .locked    (locked),
    .lastLocked(lastLocked)
  );

  assign rateCode   = lastLocked;
  assign rateCodeOe = autoS;
  assign lockDet    = locked;
  assign sdHd       = (curRate != RATE_HD);
endmodule

// File: rtl/rate_search_chk.sv
module rate_search_chk (
  input logic       clk,
  input logic       rstN,
  input logic       autoS,
  input logic       skipS,
  input logic [2:0] manualS,
  input logic [2:0] curRate,
  input logic [2:0] rateCode,
  input logic       lockDet,
  input logic       sdHd
);
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode < 3'd6) && (curRate < 3'd6)); // R1

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(lockDet) |-> $stable(rateCode)); // R4

  AST_SDHD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    lockDet |-> (sdHd == (rateCode != 3'd5))); // R7

  AST_SKIP_NO177: assert property (@(posedge clk) disable iff (!rstN)
    (autoS && skipS && $past(autoS && skipS)) |-> !(lockDet && curRate == 3'd1)); // R3

  AST_MANUAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!autoS && lockDet && $stable(manualS) && $past(!autoS)) |-> (manualS == curRate)); // R5

  AST_BADCODE_NOLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!autoS && manualS >= 3'd6) |=> !lockDet); // R6
endmodule

bind rate_search_ctrl rate_search_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .autoS   (autoS),
  .skipS   (skipS),
  .manualS (manualS),
  .curRate (curRate),
  .rateCode(rateCode),
  .lockDet (lockDet),
  .sdHd    (sdHd)
);

// File: tb/rate_search_ctrl_tb.sv
module rate_search_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 2048;
  localparam int DWELL      = 2200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       autoMode = 1'b1;
  logic       skip177 = 1'b0;
  logic [2:0] manualRate = 3'd0;
  logic       recToggle = 1'b0;
  logic [2:0] rateCode;
  logic       rateCodeOe;
  logic       lockDet;
  logic       sdHd;

  int sigUnits = 0;
  int acc = 0;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_search_ctrl #(.WIN_LOG2(11), .DWELL_CYCLES(DWELL)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .autoMode  (autoMode),
    .skip177   (skip177),
    .manualRate(manualRate),
    .recToggle (recToggle),
    .rateCode  (rateCode),
    .rateCodeOe(rateCodeOe),
    .lockDet   (lockDet),
    .sdHd      (sdHd)
  );

  // Recovered-clock model: sigUnits toggles per 2048 reference cycles
  initial begin
    forever begin
      @(negedge clk);
      acc = acc + sigUnits;
      if (acc >= 2048) begin
        acc = acc - 2048;
        recToggle = ~recToggle;
      end
    end
  end

  function automatic int rateOf(int code);
    case (code)
      0: return 143;
      1: return 177;
      2: return 270;
      3: return 360;
      4: return 540;
      5: return 1485;
      default: return 143;
    endcase
  endfunction

  function automatic int lockWait(int code, bit skip);
    int pos;
    pos = (skip && code > 1) ? code - 1 : code;
    return pos * DWELL + WIN + 300;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  task automatic checkEq(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCycles(4);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd2718);

    // Reset values and synchronizer latency (R4, R9, R7)
    autoMode = 1'b1; sigUnits = 540;
    @(negedge clk);
    checkEq("R4", "lockDet in reset", lockDet, 0);
    checkEq("R4", "rateCode in reset", rateCode, 0);
    checkEq("R7", "sdHd in reset", sdHd, 1);
    doReset();
    waitCycles(1);
    checkEq("R9", "oe after 1 edge", rateCodeOe, 0);
    waitCycles(1);
    checkEq("R9", "oe after 2 edges", rateCodeOe, 1);

    // Auto scan reaches 540 after four dwells (R2, R1)
    waitCycles(4 * DWELL - 300);
    checkEq("R2", "unlocked before 540 trial", lockDet, 0);
    waitCycles(WIN + 598);
    checkEq("R2", "lock at 540", lockDet, 1);
    checkEq("R1", "rateCode 540", rateCode, 4);
    checkEq("R7", "sdHd at 540", sdHd, 1);

    // sdHd toggles during search and scan wraps to 143 (R7, R2, R4)
    sigUnits = 0;
    doReset();
    waitCycles(5 * DWELL + 500);
    checkEq("R7", "sdHd during 1485 trial", sdHd, 0);
    checkEq("R4", "rateCode before any lock", rateCode, 0);
    sigUnits = 143;
    waitCycles(DWELL + WIN - 200);
    checkEq("R2", "wrap lock at 143", lockDet, 1);
    checkEq("R2", "wrap rateCode", rateCode, 0);
    checkEq("R7", "sdHd after wrap", sdHd, 1);

    // Skip 177 shortens path to 270; no lock at 177 (R3)
    skip177 = 1'b1; sigUnits = 270;
    doReset();
    waitCycles(DWELL + WIN + 300);
    checkEq("R3", "skip lock at 270", lockDet, 1);
    checkEq("R3", "skip rateCode", rateCode, 2);
    sigUnits = 177;
    doReset();
    waitCycles(6 * DWELL + WIN);
    checkEq("R3", "no lock at 177 skipped", lockDet, 0);
    autoMode = 1'b0; manualRate = 3'd1;
    doReset();
    waitCycles(WIN + 300);
    checkEq("R3", "manual 177 ignores skip", lockDet, 1);
    checkEq("R5", "manual oe", rateCodeOe, 0);
    skip177 = 1'b0;

    // Lock loss and reacquisition (R8, R4)
    autoMode = 1'b1; sigUnits = 270;
    doReset();
    waitCycles(2 * DWELL + WIN + 300);
    checkEq("R8", "locked at 270", lockDet, 1);
    sigUnits = 282;
    waitCycles(2 * WIN + 100);
    checkEq("R8", "lock lost at +4%", lockDet, 0);
    checkEq("R4", "rateCode keeps last lock", rateCode, 2);
    waitCycles(DWELL);
    checkEq("R8", "stays unlocked off-band", lockDet, 0);
    checkEq("R4", "rateCode still last lock", rateCode, 2);
    sigUnits = 270;
    waitCycles(7 * DWELL);
    checkEq("R8", "reacquired 270", lockDet, 1);
    checkEq("R8", "reacquired rateCode", rateCode, 2);

    // Manual mode (R5, R7)
    autoMode = 1'b0; manualRate = 3'd3; sigUnits = 360;
    doReset();
    waitCycles(WIN + 300);
    checkEq("R5", "manual lock 360", lockDet, 1);
    checkEq("R5", "manual oe low", rateCodeOe, 0);
    checkEq("R7", "sdHd manual 360", sdHd, 1);
    manualRate = 3'd5; sigUnits = 1485;
    waitCycles(WIN + 300);
    checkEq("R5", "manual lock 1485", lockDet, 1);
    checkEq("R7", "sdHd manual 1485", sdHd, 0);
    manualRate = 3'd2; sigUnits = 360;
    waitCycles(3 * DWELL);
    checkEq("R5", "no search in manual", lockDet, 0);
    checkEq("R7", "sdHd manual 270", sdHd, 1);

    // Unused manual codes (R6)
    manualRate = 3'd6; sigUnits = 143;
    waitCycles(2 * WIN + 100);
    checkEq("R6", "code 110 no lock", lockDet, 0);
    checkEq("R6", "code 110 sdHd", sdHd, 1);
    manualRate = 3'd7;
    waitCycles(2 * WIN + 100);
    checkEq("R6", "code 111 no lock", lockDet, 0);
    manualRate = 3'd0;
    waitCycles(WIN + 300);
    checkEq("R6", "code 000 locks at 143", lockDet, 1);

    // Random rates with in-band offsets (R1, R2, R3, R7)
    autoMode = 1'b1;
    for (int t = 0; t < 4; t++) begin
      int code;
      int off;
      bit skip;
      code = int'($urandom % 6);
      skip = 1'($urandom % 2);
      off  = int'($urandom % 19) - 9;
      skip177 = skip;
      sigUnits = rateOf(code) + (rateOf(code) * off) / 1000;
      doReset();
      if (skip && code == 1) begin
        waitCycles(6 * DWELL + WIN);
        checkEq("R3", "random skipped 177", lockDet, 0);
      end else begin
        waitCycles(lockWait(code, skip));
        checkEq("R1", "random lock", lockDet, 1);
        checkEq("R1", "random rateCode", rateCode, code);
        checkEq("R7", "random sdHd", sdHd, (code == 5) ? 0 : 1);
      end
    end

    finishRun();
  end
endmodule